// File: doc/BRIEF.md
# SPI Register Access Sequencer

This block runs one register access on a peripheral over a byte-wide SPI link. The host presents an address, a direction, write data and a CRC-mode bit with a one-cycle `start` pulse. The block picks the command from the address range and builds the command frame, appending a CRC7 byte when CRC mode is on. It then clocks the whole transaction under a single chip-select assertion: the command frame, then the response bytes, and for reads the data-start token and four data bytes.

When the last byte is in, the block checks the echoed opcode and the status or token byte. These sit at fixed offsets that move by one when CRC mode adds its byte. A read that passes the checks loads a 32-bit result, assembled with the first received data byte as the least significant byte. A failed check raises `err` together with `done`, and the result register keeps its previous value.

Top module: `spireg_seq`

## Requirements
- R1: A read to an address at or below 0xFF sends opcode 0xC4 and then {addr[15:8] OR 0x80, addr[7:0], 0x00}. Any other read sends opcode 0xCA and then addr[23:16], addr[15:8], addr[7:0]. Frame bytes are sent in this order.
- R2: A write to an address at or below 0x30 sends opcode 0xC3, then {addr[15:8] OR 0x80, addr[7:0]}, then the data most significant byte first. Any other write sends opcode 0xC9, then the three address bytes high to low, then the four data bytes high to low.
- R3: With `crc_en` high, one byte follows the frame. It is a CRC7 over all the frame bytes (polynomial 0x09, initial value 0x7F, bits taken most significant first), shifted left by one with bit 0 cleared. With `crc_en` low, no such byte is sent.
- R4: Let F be the frame length (4 or 5 for reads, 7, 8 or 9 for writes). A read transaction is F+7 bytes long and a write is F+2 bytes long. All of these bytes fall within one low period of `cs_n`, and `done` follows one cycle after `cs_n` rises.
- R5: A read succeeds only if received byte F equals the opcode sent and the upper nibble of byte F+2 is 0xF.
- R6: On a successful read, `rdata` takes bytes F+3 to F+6, with byte F+3 as bits 7:0. The new value is visible in the cycle `done` is high, and `rdata` changes at no other time.
- R7: A write succeeds only if received byte F equals the opcode sent and byte F+1 is 0x00.
- R8: A failed check asserts `err` in the same cycle as `done`, and `rdata` keeps its previous value.
- R9: SPI mode 0. `sclk` idles low and stays low whenever `cs_n` is high. `mosi` carries each byte most significant bit first. `miso` is sampled on the rising edge of `sclk`. Each `sclk` half-period lasts CLK_DIV clock cycles.
- R10: `busy` is high from the cycle after an accepted `start` through the cycle in which `done` is high. A `start` while `busy` is high is ignored, including a `start` in the `done` cycle.
- R11: After reset, `cs_n` is 1 and `sclk`, `busy`, `done`, `err` and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an access |
| wr_en | input | 1 | 1 = write, 0 = read |
| crc_en | input | 1 | Append a CRC7 byte to the frame |
| addr | input | 24 | Register address |
| wdata | input | 32 | Write data |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | An access is in progress or is reporting |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Check failure, valid with done |
| rdata | output | 32 | Result of the last successful read |

## Verification
The completion report and the acceptance of a new request can fall in the same cycle. The bench provokes this by holding `start` high in the exact cycle it sees `done`. It then judges the outcome by watching `cs_n` stay high for many cycles afterwards and `busy` drop. A second `start`, carrying a different address, is also pulsed while bytes are shifting. The captured frame must still match the first request, which shows that this request was ignored too.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

    localparam logic [7:0] OP_INT_WR = 8'hC3;
    localparam logic [7:0] OP_INT_RD = 8'hC4;
    localparam logic [7:0] OP_SGL_WR = 8'hC9;
    localparam logic [7:0] OP_SGL_RD = 8'hCA;

    localparam int FRAME_MAX = 9;   // longest command plus CRC byte
    localparam int IDX_W     = 4;   // byte index across a whole transaction
    localparam int RD_TAIL   = 7;   // response + token + four data bytes
    localparam int WR_TAIL   = 2;   // two response bytes

    typedef enum logic [1:0] {
        S_IDLE,
        S_LEAD,
        S_SHIFT,
        S_CHECK
    } seq_state_e;

    typedef struct packed {
        logic                          wr;
        logic [7:0]                    op;
        logic [IDX_W-1:0]              flen;
        logic [FRAME_MAX-1:0][7:0]     bytes;
    } frame_t;

    // One byte through the 7-bit CRC register, most significant bit first.
    function automatic logic [6:0] crc7_byte(input logic [6:0] c, input logic [7:0] b);
        logic [6:0] r;
        logic       fb;
        r = c;
        for (int k = 7; k >= 0; k--) begin
            fb = r[6] ^ b[k];
            r  = {r[5:0], 1'b0};
            if (fb) r = r ^ 7'h09;
        end
        return r;
    endfunction

endpackage

// File: rtl/spireg_frame.sv
module spireg_frame
    import spireg_pkg::*;
#(
    parameter int                 ADDR_W     = 24,
    parameter int                 DATA_W     = 32,
    parameter logic [ADDR_W-1:0]  INT_RD_MAX = 'h0FF,
    parameter logic [ADDR_W-1:0]  INT_WR_MAX = 'h030
) (
    input  logic              wr,
    input  logic              crc_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output frame_t            frame
);
    localparam int NB = FRAME_MAX;

    logic [NB-1:0][7:0]  body;
    logic [IDX_W-1:0]    blen;
    logic [7:0]          op;
    logic [6:0]          chain [0:NB];

    always_comb begin
        body = '0;
        blen = '0;
        op   = '0;
        if (wr) begin
            if (addr <= INT_WR_MAX) begin
                op      = OP_INT_WR;
                body[1] = addr[15:8] | 8'h80;
                body[2] = addr[7:0];
                body[3] = wdata[31:24];
                body[4] = wdata[23:16];
                body[5] = wdata[15:8];
                body[6] = wdata[7:0];
                blen    = IDX_W'(7);
            end else begin
                op      = OP_SGL_WR;
                body[1] = addr[23:16];
                body[2] = addr[15:8];
                body[3] = addr[7:0];
                body[4] = wdata[31:24];
                body[5] = wdata[23:16];
                body[6] = wdata[15:8];
                body[7] = wdata[7:0];
                blen    = IDX_W'(8);
            end
        end else begin
            if (addr <= INT_RD_MAX) begin
                op      = OP_INT_RD;
                body[1] = addr[15:8] | 8'h80;
                body[2] = addr[7:0];
                body[3] = 8'h00;
            end else begin
                op      = OP_SGL_RD;
                body[1] = addr[23:16];
                body[2] = addr[15:8];
                body[3] = addr[7:0];
            end
            blen = IDX_W'(4);
        end
        body[0] = op;
    end

    // CRC register chained through every byte position; stops advancing past blen.
    assign chain[0] = 7'h7F;
    for (genvar i = 0; i < NB; i++) begin : g_crc
        assign chain[i+1] = (IDX_W'(i) < blen) ? crc7_byte(chain[i], body[i]) : chain[i];
    end

    always_comb begin
        frame.wr    = wr;
        frame.op    = op;
        frame.bytes = body;
        frame.flen  = blen;
        if (crc_en) begin
            frame.bytes[blen] = {chain[NB], 1'b0};
            frame.flen        = blen + IDX_W'(1);
        end
    end

endmodule

// File: rtl/spireg_byte_xfer.sv
module spireg_byte_xfer #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx
);
    localparam int CW = $clog2(DIV + 1);

    logic [CW-1:0] cnt;
    logic [2:0]    nbit;
    logic [7:0]    sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            nbit <= '0;
            sh   <= '0;
            rx   <= '0;
            sclk <= 1'b0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy <= 1'b1;
                    sh   <= tx;
                    cnt  <= '0;
                    nbit <= '0;
                end
            end else if (cnt == CW'(DIV - 1)) begin
                cnt <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                    rx   <= {rx[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (nbit == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        nbit <= nbit + 3'd1;
                        sh   <= {sh[6:0], 1'b0};
                    end
                end
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign mosi = sh[7];

endmodule

// File: rtl/spireg_resp_chk.sv
module spireg_resp_chk
    import spireg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             cap,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       rx,
    input  logic             wr,
    input  logic [7:0]       op,
    input  logic [IDX_W-1:0] flen,
    output logic             ok,
    output logic [31:0]      word
);
    logic [7:0] echo_q;
    logic [7:0] stat_q;
    logic [IDX_W-1:0] stat_pos;

    assign stat_pos = wr ? flen + IDX_W'(1) : flen + IDX_W'(2);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            echo_q <= '0;
            stat_q <= '0;
        end else if (cap) begin
            if (idx == flen)     echo_q <= rx;
            if (idx == stat_pos) stat_q <= rx;
        end
    end

    for (genvar g = 0; g < 4; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                word[8*g +: 8] <= '0;
            end else if (cap && !wr && idx == flen + IDX_W'(3 + g)) begin
                word[8*g +: 8] <= rx;
            end
        end
    end

    assign ok = (echo_q == op) && (wr ? (stat_q == 8'h00) : (stat_q[7:4] == 4'hF));

endmodule

// File: rtl/spireg_seq.sv
module spireg_seq
    import spireg_pkg::*;
#(
    parameter int                 ADDR_W     = 24,
    parameter int                 DATA_W     = 32,
    parameter int                 CLK_DIV    = 2,
    parameter logic [ADDR_W-1:0]  INT_RD_MAX = 'h0FF,
    parameter logic [ADDR_W-1:0]  INT_WR_MAX = 'h030
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr_en,
    input  logic              crc_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata
);
    seq_state_e       state;
    frame_t           fr_d, fr_q;
    logic [IDX_W-1:0] idx, last_idx, lidx;
    logic             go, bdone, bbusy, accept, cap, ok;
    logic [7:0]       tx_byte, rx_byte;
    logic [31:0]      rd_word;

    spireg_frame #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .INT_RD_MAX(INT_RD_MAX), .INT_WR_MAX(INT_WR_MAX)
    ) u_frame (
        .wr(wr_en), .crc_en(crc_en), .addr(addr), .wdata(wdata), .frame(fr_d)
    );

    assign accept = start && state == S_IDLE && !done;
    assign cap    = state == S_SHIFT && bdone;
    assign go     = state == S_LEAD || (cap && idx != last_idx);
    assign lidx   = (state == S_LEAD) ? '0 : idx + IDX_W'(1);
    assign tx_byte = (lidx < fr_q.flen) ? fr_q.bytes[lidx] : 8'h00;

    spireg_byte_xfer #(.DIV(CLK_DIV)) u_xfer (
        .clk(clk), .rst(rst), .go(go), .tx(tx_byte), .miso(miso),
        .sclk(sclk), .mosi(mosi), .busy(bbusy), .done(bdone), .rx(rx_byte)
    );

    spireg_resp_chk u_chk_resp (
        .clk(clk), .rst(rst), .clear(accept), .cap(cap), .idx(idx), .rx(rx_byte),
        .wr(fr_q.wr), .op(fr_q.op), .flen(fr_q.flen), .ok(ok), .word(rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            fr_q     <= '0;
            idx      <= '0;
            last_idx <= '0;
            cs_n     <= 1'b1;
            done     <= 1'b0;
            err      <= 1'b0;
            rdata    <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                S_IDLE: if (accept) begin
                    fr_q     <= fr_d;
                    idx      <= '0;
                    last_idx <= fr_d.flen + (wr_en ? IDX_W'(WR_TAIL - 1) : IDX_W'(RD_TAIL - 1));
                    cs_n     <= 1'b0;
                    state    <= S_LEAD;
                end
                S_LEAD: state <= S_SHIFT;
                S_SHIFT: if (bdone) begin
                    if (idx == last_idx) begin
                        cs_n  <= 1'b1;
                        state <= S_CHECK;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                S_CHECK: begin
                    done  <= 1'b1;
                    err   <= !ok;
                    if (!fr_q.wr && ok) rdata <= DATA_W'(rd_word);
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy = (state != S_IDLE) || done;

    logic unused_ok;
    assign unused_ok = bbusy;

endmodule

// File: rtl/spireg_seq_chk.sv
module spireg_seq_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              cs_n,
    input logic              sclk,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [DATA_W-1:0] rdata
);
    // R9: clock parked low whenever the peripheral is deselected
    a_r9_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R8: error never reported without completion
    a_r8_err_only_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R8: failed access leaves the result untouched
    a_r8_rdata_held_on_err: assert property (@(posedge clk) disable iff (rst)
        err |-> $stable(rdata));

    // R10: a request in the completion cycle does not open a new transaction
    a_r10_no_restart_after_done: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> cs_n);

    // R10: busy covers the completion cycle
    a_r10_busy_with_done: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R4: completion follows release of chip select by one cycle
    a_r4_report_after_release: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> done);

    // R6: result register moves only with completion
    a_r6_rdata_moves_only_on_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> done);
endmodule

bind spireg_seq spireg_seq_chk #(.DATA_W(DATA_W)) u_seq_chk (
    .clk(clk), .rst(rst), .start(start), .cs_n(cs_n), .sclk(sclk),
    .busy(busy), .done(done), .err(err), .rdata(rdata)
);

// File: tb/spireg_seq_bench.sv
`timescale 1ns/1ps
module spireg_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, wr_en = 1'b0, crc_en = 1'b0;
    logic [23:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        miso = 1'b0;
    logic        sclk, mosi, cs_n, busy, done, err;
    logic [31:0] rdata;

    always #10 clk = ~clk;   // 50 MHz

    spireg_seq u_spireg_seq (
        .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .crc_en(crc_en),
        .addr(addr), .wdata(wdata), .miso(miso), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .busy(busy), .done(done), .err(err), .rdata(rdata)
    );

    int n_chk = 0, n_err = 0;
    logic [31:0] exp_rdata = '0;

    task automatic check(input logic cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!cond) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Peripheral model
    logic [7:0] resp [16];
    logic [7:0] seen [16];
    int nbytes = 0, bitc = 0;
    logic [7:0] cur = '0;

    initial forever begin
        @(negedge cs_n);
        nbytes = 0; bitc = 0;
        miso <= resp[0][7];
    end
    initial forever begin
        @(posedge sclk);
        cur = {cur[6:0], mosi};
        bitc++;
        if (bitc == 8) begin
            if (nbytes < 16) seen[nbytes] = cur;
            nbytes++;
            bitc = 0;
        end
    end
    initial forever begin
        @(negedge sclk);
        if (nbytes < 16) miso <= resp[nbytes][7-bitc];
    end

    // Expected frame per R1, R2, R3
    logic [7:0] ef [12];
    int         eflen;
    logic [7:0] eop;

    function automatic logic [6:0] crc_ref(input logic [6:0] c, input logic [7:0] b);
        logic [6:0] r = c;
        for (int k = 7; k >= 0; k--) begin
            logic fb = r[6] ^ b[k];
            r = {r[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return r;
    endfunction

    task automatic build_expect(input logic w, input logic c, input logic [23:0] a, input logic [31:0] d);
        logic [6:0] cr = 7'h7F;
        for (int i = 0; i < 12; i++) ef[i] = 8'h00;
        if (w && a <= 24'h30) begin
            eop = 8'hC3; ef[1] = a[15:8] | 8'h80; ef[2] = a[7:0];
            ef[3] = d[31:24]; ef[4] = d[23:16]; ef[5] = d[15:8]; ef[6] = d[7:0]; eflen = 7;
        end else if (w) begin
            eop = 8'hC9; ef[1] = a[23:16]; ef[2] = a[15:8]; ef[3] = a[7:0];
            ef[4] = d[31:24]; ef[5] = d[23:16]; ef[6] = d[15:8]; ef[7] = d[7:0]; eflen = 8;
        end else if (a <= 24'hFF) begin
            eop = 8'hC4; ef[1] = a[15:8] | 8'h80; ef[2] = a[7:0]; ef[3] = 8'h00; eflen = 4;
        end else begin
            eop = 8'hCA; ef[1] = a[23:16]; ef[2] = a[15:8]; ef[3] = a[7:0]; eflen = 4;
        end
        ef[0] = eop;
        if (c) begin
            for (int i = 0; i < eflen; i++) cr = crc_ref(cr, ef[i]);
            ef[eflen] = {cr, 1'b0};
            eflen++;
        end
    endtask

    // bad: 0 good, 1 wrong echo, 2 bad token/status
    task automatic build_resp(input logic w, input logic [1:0] bad, input logic [31:0] d);
        for (int i = 0; i < 16; i++) resp[i] = 8'h5A;
        resp[eflen] = (bad == 2'd1) ? (eop ^ 8'h01) : eop;
        if (w) begin
            resp[eflen+1] = (bad == 2'd2) ? 8'h01 : 8'h00;
        end else begin
            resp[eflen+1] = 8'h00;
            resp[eflen+2] = (bad == 2'd2) ? 8'h03 : 8'hF3;
            resp[eflen+3] = d[7:0];   resp[eflen+4] = d[15:8];
            resp[eflen+5] = d[23:16]; resp[eflen+6] = d[31:24];
        end
    endtask

    task automatic wait_done(output logic ok);
        ok = 1'b0;
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; return; end
        end
    endtask

    task automatic frame_checks(input logic w, input logic c);
        logic same = 1'b1;
        int   tot = eflen + (w ? 2 : 7);
        for (int i = 0; i < eflen; i++) if (seen[i] !== ef[i]) same = 1'b0;
        check(same, w ? (c ? "R2 R3 R9 write frame" : "R2 R9 write frame")
                      : (c ? "R1 R3 R9 read frame" : "R1 R9 read frame"),
              {seen[0], seen[1], seen[2], seen[3]}, {ef[0], ef[1], ef[2], ef[3]});
        check(nbytes == tot, "R4 byte count", 64'(nbytes), 64'(tot));
    endtask

    // wr, crc, bad[1:0], addr[23:0], data[31:0]
    localparam int NV = 12;
    localparam logic [59:0] VEC [NV] = '{
        {1'b0, 1'b0, 2'd0, 24'h0000FF, 32'h11223344},
        {1'b0, 1'b0, 2'd0, 24'h000100, 32'hA5A55A5A},
        {1'b0, 1'b1, 2'd0, 24'h00001C, 32'hDEADBEEF},
        {1'b0, 1'b1, 2'd0, 24'h1234AB, 32'h0BADF00D},
        {1'b1, 1'b0, 2'd0, 24'h000030, 32'hCAFEBABE},
        {1'b1, 1'b0, 2'd0, 24'h000031, 32'h01020304},
        {1'b1, 1'b1, 2'd0, 24'h000010, 32'h89ABCDEF},
        {1'b1, 1'b1, 2'd0, 24'h10A000, 32'h55AA00FF},
        {1'b0, 1'b1, 2'd1, 24'h000100, 32'h77777777},
        {1'b0, 1'b0, 2'd2, 24'h000040, 32'h66666666},
        {1'b1, 1'b0, 2'd2, 24'h000100, 32'h12345678},
        {1'b1, 1'b1, 2'd1, 24'h000020, 32'h9ABCDEF0}
    };

    logic finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic ok;
        for (int i = 0; i < 16; i++) resp[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0 && err == 1'b0 && rdata == 32'h0,
              "R11 reset state", {58'h0, cs_n, sclk, busy, done, err, |rdata}, 64'h20);

        for (int v = 0; v < NV; v++) begin
            logic        w = VEC[v][59];
            logic        c = VEC[v][58];
            logic [1:0]  bad = VEC[v][57:56];
            logic [23:0] a = VEC[v][55:32];
            logic [31:0] d = VEC[v][31:0];
            build_expect(w, c, a, d);
            build_resp(w, bad, d);
            wr_en = w; crc_en = c; addr = a; wdata = d; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b1 && cs_n == 1'b0, "R10 busy after start", {busy, cs_n}, 2'b10);
            wait_done(ok);
            check(ok, "R4 done seen", 64'(ok), 64'd1);
            frame_checks(w, c);
            check(err == (bad != 0), w ? "R7 R8 write status" : "R5 R8 read status", 64'(err), 64'(bad != 0));
            if (!w && bad == 0) exp_rdata = d;
            check(rdata == exp_rdata, (bad != 0) ? "R8 rdata kept" : "R6 rdata value", 64'(rdata), 64'(exp_rdata));
            @(negedge clk);
        end

        // R10: start mid-transfer and in the done cycle are ignored
        begin
            logic stayed = 1'b1;
            build_expect(1'b0, 1'b0, 24'h000200, 32'h13579BDF);
            build_resp(1'b0, 2'd0, 32'h13579BDF);
            wr_en = 1'b0; crc_en = 1'b0; addr = 24'h000200; wdata = '0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (50) @(negedge clk);
            wr_en = 1'b1; addr = 24'h000031; start = 1'b1;
            @(negedge clk);
            start = 1'b0; wr_en = 1'b0; addr = 24'h000200;
            wait_done(ok);
            exp_rdata = 32'h13579BDF;
            frame_checks(1'b0, 1'b0);
            check(rdata == exp_rdata, "R10 R6 first request completed", 64'(rdata), 64'(exp_rdata));
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int t = 0; t < 40; t++) begin
                if (cs_n !== 1'b1) stayed = 1'b0;
                @(negedge clk);
            end
            check(stayed, "R10 start in done cycle ignored", 64'(stayed), 64'd1);
            check(busy == 1'b0, "R10 idle afterwards", 64'(busy), 64'd0);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule